// File: doc/BRIEF.md
# Circular Playback Address Engine

The engine walks a ring of sample data in memory on behalf of an audio output path. Software supplies the first and one-past-last addresses of the ring, an alert threshold, and finally a stop address. Writing the stop address while the engine is idle launches playback. From then on the engine requests one 16-byte fetch at a time. It moves to the next line on each acknowledge and jumps from the ring's last line back to its first. Playback ends when the next line it would fetch is the stop address.

Software chooses between a single pass and an endless loop through the stop address it programs. If the stop address equals the ring start, the whole ring plays once. If it equals the ring end, lies outside the ring, or is not a multiple of 16 bytes, it is never reached and the ring repeats until a stop request arrives. A countdown of the remaining data in 8-byte units is kept beside the address. It is loaded only at launch and is never reloaded on a wrap, so it runs below zero and wraps to a large value. A one-cycle alert is raised whenever the countdown lands on the programmed threshold.

Top module: `circ_play_engine`

## Requirements
- R1: After reset the engine is idle: no fetch request, active low, current address 0, remaining count 0, and both event outputs low.
- R2: A stop-address write while idle starts playback on the next cycle: active goes high, the current address becomes the ring start, and a fetch request for the ring start is presented.
- R3: A stop-address write made while playback is active is ignored, and the run ends at the stop address captured at launch.
- R4: A fetch request is held with an unchanged address until acknowledged. Each acknowledge moves the current address forward by 16 bytes.
- R5: The ring end is exclusive. The line after the one at ring end minus 16 bytes is the ring start.
- R6: Playback ends after the acknowledge whose next line equals the stop address, compared at 8-byte resolution (byte-address bit 3 is significant). A stop address equal to the ring start plays every line once. A stop address inside the ring plays the lines from the start up to, but not including, it.
- R7: A stop address equal to the ring end, outside the ring, or with bit 3 set is never reached, and playback loops until stopped.
- R8: When playback ends, whether at the stop address or by request, active drops and the current address returns to the ring start.
- R9: At launch the remaining count is (stop − start)/8 if the stop address is above the ring start, and otherwise ((end − start) + (stop − start))/8, modulo 2^(ADDR_W−3). Each acknowledge lowers it by 2, with wraparound and no reload at the ring wrap.
- R10: The alert output pulses for one cycle, in the cycle after a launch or an acknowledge, when the newly loaded remaining count equals the threshold input.
- R11: A stop request while active halts playback at the next edge. It takes priority over an acknowledge in the same cycle, and the stopped event pulses for one cycle. A stop request while idle changes nothing and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_start_i | input | ADDR_W-4 | Ring start, byte-address bits [ADDR_W-1:4] |
| buf_end_i | input | ADDR_W-4 | Ring end (exclusive), byte-address bits [ADDR_W-1:4] |
| end_addr_i | input | ADDR_W-3 | Stop address, byte-address bits [ADDR_W-1:3] |
| end_wr_i | input | 1 | One-cycle write strobe for the stop address |
| alert_cnt_i | input | ADDR_W-3 | Alert threshold in 8-byte units |
| stop_req_i | input | 1 | Request to halt playback |
| fetch_ack_i | input | 1 | Memory accepted the current fetch |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | ADDR_W-4 | Fetch line address, byte-address bits [ADDR_W-1:4] |
| cur_addr_o | output | ADDR_W | Current playback byte address |
| remain_o | output | ADDR_W-3 | Remaining count in 8-byte units |
| active_o | output | 1 | Playback running |
| alert_evt_o | output | 1 | One-cycle position alert |
| stop_evt_o | output | 1 | One-cycle stopped-by-request event |

## Verification
The properties assume that the ring start and ring end stay constant during a run, that the ring start is below the ring end, and that the alert threshold only changes between runs. The stimulus sets all three only while the engine is idle. The stall checks assume that the memory side may hold its acknowledge low for any number of cycles. The bench exercises this with a run whose acknowledges are withheld, alongside runs that are acknowledged on every cycle.

// File: rtl/circ_play_pkg.sv
// Shared constants and types for the circular playback address engine.
// Assumes fetch lines of 16 bytes and a remaining count kept in 8-byte units.
package circ_play_pkg;
    localparam int UNIT_SH = 3;                         // count unit is 2^3 bytes
    localparam int BLK_SH  = 4;                         // fetch line is 2^4 bytes
    localparam int STEP_U  = 1 << (BLK_SH - UNIT_SH);   // units per fetch line

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_RUN  = 1'b1
    } pb_state_e;
endpackage

// File: rtl/circ_play_dist.sv
// Launch distance: the length, in 8-byte units, from the ring start to the
// stop address, going round the ring when the stop address does not lie
// above the start. Combinational. Assumes start < end for a valid ring.
module circ_play_dist #(
    parameter int U_W = 25
) (
    input  logic [U_W-1:0] from_u,
    input  logic [U_W-1:0] to_u,
    input  logic [U_W-1:0] bstart_u,
    input  logic [U_W-1:0] bend_u,
    output logic [U_W-1:0] dist_u
);
    logic ahead;

    // Pick the direct span or the span that wraps through the ring end.
    always_comb begin
        ahead = (to_u > from_u);
        if (ahead) begin
            dist_u = to_u - from_u;
        end else begin
            dist_u = (bend_u - from_u) + (to_u - bstart_u);
        end
    end
endmodule

// File: rtl/circ_play_step.sv
// Next-line generator: advances the current address by one fetch line and
// wraps to the ring start at the exclusive ring end, then flags whether the
// advanced line is the stop address. Combinational.
module circ_play_step
    import circ_play_pkg::*;
#(
    parameter int U_W = 25
) (
    input  logic [U_W-1:0] cur_u,
    input  logic [U_W-1:0] bstart_u,
    input  logic [U_W-1:0] bend_u,
    input  logic [U_W-1:0] endp_u,
    output logic [U_W-1:0] nxt_u,
    output logic           last
);
    logic [U_W-1:0] raw_u;
    logic           wrap;

    // Advance, fold back at the ring end, and compare against the stop point.
    always_comb begin
        raw_u = cur_u + U_W'(STEP_U);
        wrap  = (raw_u == bend_u);
        nxt_u = wrap ? bstart_u : raw_u;
        last  = (nxt_u == endp_u);
    end
endmodule

// File: rtl/circ_play_ctrl.sv
// Sequencer for the playback engine. Holds run state, current address,
// captured stop address, the remaining count and the one-cycle events.
// Assumes the ring bounds are stable during a run.
module circ_play_ctrl
    import circ_play_pkg::*;
#(
    parameter int U_W = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           end_wr,
    input  logic [U_W-1:0] end_in_u,
    input  logic           stop_req,
    input  logic           ack,
    input  logic [U_W-1:0] bstart_u,
    input  logic [U_W-1:0] launch_dist_u,
    input  logic [U_W-1:0] nxt_u,
    input  logic           last,
    input  logic [U_W-1:0] alert_cnt,
    output logic           active,
    output logic [U_W-1:0] cur_u,
    output logic [U_W-1:0] endp_u,
    output logic [U_W-1:0] remain_u,
    output logic           alert_evt,
    output logic           stop_evt
);
    pb_state_e      state;
    logic [U_W-1:0] remain_dec;

    // Count after one more fetch line is consumed.
    always_comb begin
        remain_dec = remain_u - U_W'(STEP_U);
    end

    // Run-state sequencing, address and count updates, and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PB_IDLE;
            cur_u     <= '0;
            endp_u    <= '0;
            remain_u  <= '0;
            alert_evt <= 1'b0;
            stop_evt  <= 1'b0;
        end else begin
            alert_evt <= 1'b0;
            stop_evt  <= 1'b0;
            unique case (state)
                PB_IDLE: begin
                    if (end_wr) begin
                        state     <= PB_RUN;
                        endp_u    <= end_in_u;
                        cur_u     <= bstart_u;
                        remain_u  <= launch_dist_u;
                        alert_evt <= (launch_dist_u == alert_cnt);
                    end
                end
                PB_RUN: begin
                    if (stop_req) begin
                        state    <= PB_IDLE;
                        cur_u    <= bstart_u;
                        stop_evt <= 1'b1;
                    end else if (ack) begin
                        remain_u  <= remain_dec;
                        alert_evt <= (remain_dec == alert_cnt);
                        if (last) begin
                            state <= PB_IDLE;
                            cur_u <= bstart_u;
                        end else begin
                            cur_u <= nxt_u;
                        end
                    end
                end
                default: state <= PB_IDLE;
            endcase
        end
    end

    // Expose run state as a flag.
    always_comb begin
        active = (state == PB_RUN);
    end
endmodule

// File: rtl/circ_play_engine.sv
// Circular playback address engine, top level. Converts byte-address register
// inputs to 8-byte units, joins the launch-distance, next-line and sequencer
// pieces, and presents one fetch request at a time to memory.
// Assumes the ring start is below the ring end and both are 16-byte aligned.
module circ_play_engine
    import circ_play_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:BLK_SH]     buf_start_i,
    input  logic [ADDR_W-1:BLK_SH]     buf_end_i,
    input  logic [ADDR_W-1:UNIT_SH]    end_addr_i,
    input  logic                       end_wr_i,
    input  logic [ADDR_W-UNIT_SH-1:0]  alert_cnt_i,
    input  logic                       stop_req_i,
    input  logic                       fetch_ack_i,
    output logic                       fetch_req_o,
    output logic [ADDR_W-1:BLK_SH]     fetch_addr_o,
    output logic [ADDR_W-1:0]          cur_addr_o,
    output logic [ADDR_W-UNIT_SH-1:0]  remain_o,
    output logic                       active_o,
    output logic                       alert_evt_o,
    output logic                       stop_evt_o
);
    localparam int U_W  = ADDR_W - UNIT_SH;
    localparam int PAD  = BLK_SH - UNIT_SH;

    logic [U_W-1:0] bstart_u;
    logic [U_W-1:0] bend_u;
    logic [U_W-1:0] end_in_u;
    logic [U_W-1:0] launch_dist_u;
    logic [U_W-1:0] cur_u;
    logic [U_W-1:0] endp_u;
    logic [U_W-1:0] nxt_u;
    logic           last;
    logic           active;

    // Scale register inputs to 8-byte units.
    always_comb begin
        bstart_u = {buf_start_i, {PAD{1'b0}}};
        bend_u   = {buf_end_i, {PAD{1'b0}}};
        end_in_u = end_addr_i;
    end

    circ_play_dist #(.U_W(U_W)) u_dist (
        .from_u   (bstart_u),
        .to_u     (end_in_u),
        .bstart_u (bstart_u),
        .bend_u   (bend_u),
        .dist_u   (launch_dist_u)
    );

    circ_play_step #(.U_W(U_W)) u_step (
        .cur_u    (cur_u),
        .bstart_u (bstart_u),
        .bend_u   (bend_u),
        .endp_u   (endp_u),
        .nxt_u    (nxt_u),
        .last     (last)
    );

    circ_play_ctrl #(.U_W(U_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .end_wr        (end_wr_i),
        .end_in_u      (end_in_u),
        .stop_req      (stop_req_i),
        .ack           (fetch_ack_i),
        .bstart_u      (bstart_u),
        .launch_dist_u (launch_dist_u),
        .nxt_u         (nxt_u),
        .last          (last),
        .alert_cnt     (alert_cnt_i),
        .active        (active),
        .cur_u         (cur_u),
        .endp_u        (endp_u),
        .remain_u      (remain_o),
        .alert_evt     (alert_evt_o),
        .stop_evt      (stop_evt_o)
    );

    // Drive the memory-side and status outputs from the sequencer state.
    always_comb begin
        fetch_req_o  = active;
        active_o     = active;
        fetch_addr_o = cur_u[U_W-1:PAD];
        cur_addr_o   = {cur_u, {UNIT_SH{1'b0}}};
    end
endmodule

// File: rtl/circ_play_checks.sv
// Property checker for the circular playback address engine, bound to the
// top. Assumes ring bounds and threshold are held while a run is active.
module circ_play_checks
    import circ_play_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:BLK_SH]     buf_start_i,
    input  logic                       end_wr_i,
    input  logic [ADDR_W-UNIT_SH-1:0]  alert_cnt_i,
    input  logic                       stop_req_i,
    input  logic                       fetch_ack_i,
    input  logic                       fetch_req_o,
    input  logic [ADDR_W-1:BLK_SH]     fetch_addr_o,
    input  logic [ADDR_W-1:0]          cur_addr_o,
    input  logic [ADDR_W-UNIT_SH-1:0]  remain_o,
    input  logic                       active_o,
    input  logic                       alert_evt_o,
    input  logic                       stop_evt_o
);
    localparam int U_W = ADDR_W - UNIT_SH;

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && end_wr_i) |=> (active_o && fetch_addr_o == $past(buf_start_i)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_ack_i && !stop_req_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_ack_i && !stop_req_i) |=>
            (fetch_addr_o == $past(fetch_addr_o) + 1'b1 || fetch_addr_o == buf_start_i));

    a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_o) |-> (cur_addr_o == {$past(buf_start_i), 4'b0000}));

    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && fetch_ack_i && !stop_req_i) |=> (remain_o == $past(remain_o) - U_W'(STEP_U)));

    a_r10_alert: assert property (@(posedge clk) disable iff (!rst_n)
        alert_evt_o |-> (remain_o == $past(alert_cnt_i)));

    a_r11_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && stop_req_i) |=> (stop_evt_o && !active_o));

    a_r11_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && stop_req_i) |=> !stop_evt_o);
endmodule

bind circ_play_engine circ_play_checks #(.ADDR_W(ADDR_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .buf_start_i  (buf_start_i),
    .end_wr_i     (end_wr_i),
    .alert_cnt_i  (alert_cnt_i),
    .stop_req_i   (stop_req_i),
    .fetch_ack_i  (fetch_ack_i),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .cur_addr_o   (cur_addr_o),
    .remain_o     (remain_o),
    .active_o     (active_o),
    .alert_evt_o  (alert_evt_o),
    .stop_evt_o   (stop_evt_o)
);

// File: tb/circ_play_engine_bench.sv
`timescale 1ns/1ps
module circ_play_engine_bench;
    localparam int AW = 28;
    localparam int UW = AW - 3;

    typedef struct packed {
        logic [27:0] bs;
        logic [27:0] be;
        logic [27:0] ea;
        logic [24:0] al;
        logic [7:0]  lim;   // 0: expect natural end, else stop after lim fetches
        logic [7:0]  nf;    // expected fetch count
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{28'h1000, 28'h1080, 28'h1000, 25'd4,       8'd0,  8'd8},   // once through
        '{28'h1000, 28'h1080, 28'h1040, 25'd8,       8'd0,  8'd4},   // partial, alert at launch
        '{28'h1000, 28'h1080, 28'h1080, 25'd0,       8'd20, 8'd20},  // stop at ring end: loops
        '{28'h1000, 28'h1080, 28'h1008, 25'h1FFFFFD, 8'd20, 8'd20},  // off-grid stop: loops
        '{28'h1000, 28'h1080, 28'h2000, 25'h1F0,     8'd20, 8'd20},  // outside ring: loops
        '{28'h0300, 28'h0340, 28'h0320, 25'd0,       8'd0,  8'd2}    // small ring, alert at end
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:4] buf_start_i = '0;
    logic [AW-1:4] buf_end_i = '0;
    logic [AW-1:3] end_addr_i = '0;
    logic          end_wr_i = 1'b0;
    logic [UW-1:0] alert_cnt_i = '0;
    logic          stop_req_i = 1'b0;
    logic          fetch_ack_i = 1'b0;
    logic          fetch_req_o;
    logic [AW-1:4] fetch_addr_o;
    logic [AW-1:0] cur_addr_o;
    logic [UW-1:0] remain_o;
    logic          active_o;
    logic          alert_evt_o;
    logic          stop_evt_o;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    circ_play_engine #(.ADDR_W(AW)) u_circ_play_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .buf_start_i  (buf_start_i),
        .buf_end_i    (buf_end_i),
        .end_addr_i   (end_addr_i),
        .end_wr_i     (end_wr_i),
        .alert_cnt_i  (alert_cnt_i),
        .stop_req_i   (stop_req_i),
        .fetch_ack_i  (fetch_ack_i),
        .fetch_req_o  (fetch_req_o),
        .fetch_addr_o (fetch_addr_o),
        .cur_addr_o   (cur_addr_o),
        .remain_o     (remain_o),
        .active_o     (active_o),
        .alert_evt_o  (alert_evt_o),
        .stop_evt_o   (stop_evt_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Launch distance in 8-byte units, per the R9 formula.
    function automatic logic [24:0] launch_dist(input logic [27:0] bs, input logic [27:0] be, input logic [27:0] ea);
        logic [27:0] d;
        if (ea > bs) d = ea - bs;
        else         d = (be - bs) + (ea - bs);
        return d[27:3];
    endfunction

    task automatic set_ring(input logic [27:0] bs, input logic [27:0] be, input logic [24:0] al);
        buf_start_i = bs[27:4];
        buf_end_i   = be[27:4];
        alert_cnt_i = al;
    endtask

    task automatic write_end(input logic [27:0] ea);
        end_addr_i = ea[27:3];
        end_wr_i   = 1'b1;
        @(negedge clk);
        end_wr_i   = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!active_o && !fetch_req_o, "R1 idle after reset", {30'd0, active_o, fetch_req_o}, 32'd0);
        chk(cur_addr_o == '0, "R1 current address", 32'(cur_addr_o), 32'd0);
        chk(remain_o == '0, "R1 remaining count", 32'(remain_o), 32'd0);
        chk(!alert_evt_o && !stop_evt_o, "R1 events low", {30'd0, alert_evt_o, stop_evt_o}, 32'd0);

        // Vector table, acknowledged every cycle.
        fetch_ack_i = 1'b1;
        for (int v = 0; v < 6; v++) begin
            logic [27:0] m_addr;
            logic [27:0] nx;
            logic [24:0] m_rem;
            int  fetches;
            int  bad;
            int  exp_al;
            int  obs_al;
            bit  stopped;
            set_ring(VECS[v].bs, VECS[v].be, VECS[v].al);
            write_end(VECS[v].ea);
            m_addr  = VECS[v].bs;
            m_rem   = launch_dist(VECS[v].bs, VECS[v].be, VECS[v].ea);
            exp_al  = (m_rem == VECS[v].al) ? 1 : 0;
            obs_al  = 0;
            fetches = 0;
            bad     = 0;
            stopped = 1'b0;
            if (v == 0) chk(active_o && fetch_addr_o == VECS[v].bs[27:4], "R2 launch at ring start",
                            32'(fetch_addr_o), 32'(VECS[v].bs[27:4]));
            for (int c = 0; c < 400; c++) begin
                if (alert_evt_o) obs_al++;
                if (remain_o !== m_rem) bad++;
                if (!active_o) break;
                if (fetch_addr_o !== m_addr[27:4]) bad++;
                fetches++;
                if (VECS[v].lim != 0 && fetches == int'(VECS[v].lim)) begin
                    stop_req_i = 1'b1;
                    @(negedge clk);
                    stop_req_i = 1'b0;
                    stopped = 1'b1;
                    break;
                end
                m_rem = m_rem - 25'd2;
                if (m_rem == VECS[v].al) exp_al++;
                nx = m_addr + 28'h10;
                if (nx == VECS[v].be) nx = VECS[v].bs;
                m_addr = (nx == VECS[v].ea) ? VECS[v].bs : nx;
                @(negedge clk);
            end
            chk(bad == 0, "R4 R5 R9 address and count sequence", 32'(bad), 32'd0);
            chk(fetches == int'(VECS[v].nf), VECS[v].lim != 0 ? "R7 loops until stopped" : "R6 fetch count to stop address",
                32'(fetches), 32'(VECS[v].nf));
            chk(obs_al == exp_al, "R10 alert pulses", 32'(obs_al), 32'(exp_al));
            chk(!active_o && cur_addr_o == VECS[v].bs, "R8 back at ring start", 32'(cur_addr_o), 32'(VECS[v].bs));
            if (stopped) chk(stop_evt_o, "R11 stopped event", 32'(stop_evt_o), 32'd1);
            @(negedge clk);
            if (stopped) chk(!stop_evt_o, "R11 stopped event lasts one cycle", 32'(stop_evt_o), 32'd0);
        end

        // R4 stall and R3 ignored write during a run.
        fetch_ack_i = 1'b0;
        set_ring(28'h1000, 28'h1080, 25'h1FFFFFF);
        write_end(28'h1040);
        chk(active_o && fetch_addr_o == 24'h100, "R2 launch with stalled memory", 32'(fetch_addr_o), 32'h100);
        repeat (3) @(negedge clk);
        chk(fetch_req_o && fetch_addr_o == 24'h100, "R4 request held while unacknowledged", 32'(fetch_addr_o), 32'h100);
        chk(remain_o == 25'd8, "R9 count held while unacknowledged", 32'(remain_o), 32'd8);
        write_end(28'h1000);
        fetch_ack_i = 1'b1;
        begin
            int n;
            n = 0;
            for (int c = 0; c < 50; c++) begin
                if (!active_o) break;
                n++;
                @(negedge clk);
            end
            chk(n == 4, "R3 write while active ignored", 32'(n), 32'd4);
        end

        // R11: stop request while idle does nothing.
        fetch_ack_i = 1'b0;
        stop_req_i = 1'b1;
        @(negedge clk);
        stop_req_i = 1'b0;
        chk(!stop_evt_o && !active_o, "R11 idle stop ignored", {30'd0, stop_evt_o, active_o}, 32'd0);
        chk(cur_addr_o == 28'h1000, "R11 idle stop leaves address", 32'(cur_addr_o), 32'h1000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule